// File: doc/BRIEF.md
# Presettable Johnson Divide-by-N Counter

A five-stage twisted-ring counter that divides its input clock by a whole number from 2 to 10. The ratio is picked on a four-bit select input. It sets which stage outputs feed the first stage. For an even ratio the first stage takes the inverse of one stage, so the ring walks through twice as many states as it has active stages. For an odd ratio a two-input NAND of two neighbouring stages drives the first stage, and one state drops out of the cycle.

Two asynchronous controls override the count. Reset sets every stage to 1. The preset control loads the inverse of a five-bit jam word into the stages. When neither is active, the ring advances on each rising clock edge. Legality gating watches the active part of the ring. If that part holds a pattern that is not in the current cycle, the next edge reloads all ones, so the counter can never lock up in a stray loop. All five stage outputs are visible. Stage 0 also serves as the divided clock.

Top module: `johnson_divider`

## Requirements
- R1: While `rst` is 1, all five bits of `stage_q` are 1, at once and without waiting for a clock edge, whatever `preset_en` does.
- R2: While `preset_en` is 1 and `rst` is 0, `stage_q` equals the bitwise inverse of `jam`. The load happens at once when `preset_en` rises and is repeated on every clock edge while it stays high.
- R3: On a rising `clk` edge with both controls low and a legal state, each stage k from 1 to 4 takes the value stage k-1 held before the edge.
- R4: For an even effective ratio 2N (N from 1 to 5), stage 0 takes the inverse of stage N-1 on each counting edge.
- R5: For an odd effective ratio 2N-1 (N from 2 to 5), stage 0 takes the NAND of stages N-2 and N-1 on each counting edge.
- R6: A `ratio` code of 0, 1 or 11 to 15 behaves exactly like code 10.
- R7: The active window is stages 0 to M-1, where M = (ratio+1)/2 using integer division. The state is legal when that window holds a value reached from all ones under the R4/R5 rule. For even ratios these are the values with at most one position where adjacent stages differ. For odd ratios the all-zero window is excluded as well. A counting edge from an illegal state loads all ones.
- R8: `div_out` equals `stage_q[0]`. Starting from a legal state with a fixed ratio, successive rising edges of `div_out` are exactly ratio clock periods apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, rising edge active |
| rst | input | 1 | Asynchronous set of all stages to 1, highest priority |
| preset_en | input | 1 | Asynchronous load of the inverted jam word |
| jam | input | 5 | Preset data, loaded inverted |
| ratio | input | 4 | Division ratio code, 2 to 10 valid |
| stage_q | output | 5 | Stage outputs, bit 0 is the first stage |
| div_out | output | 1 | Divided clock, taken from stage 0 |

## Verification
In normal counting the ring never leaves its legal cycle. So the legality gating, and the odd-mode case where the window is all zero, can only be reached by loading a chosen pattern through the preset. The bench holds the preset control high across one clock edge and then releases it. It does this with stray patterns for both an even and an odd ratio, and then checks that the very next edge restores all ones. The bench checks the asynchronous paths in the middle of a clock phase, before any edge could mask them. It measures the period of the divided clock by counting edges between rises, for every valid code and for several invalid ones.

// File: rtl/jdiv_pkg.sv
package jdiv_pkg;

  // Default ring length.
  localparam int unsigned JDIV_STAGES_DEFAULT = 5;

  // Largest ratio a ring of the given length can reach.
  function automatic int unsigned jdiv_max_ratio(input int unsigned stages);
    return 2 * stages;
  endfunction

  // Width of a ratio code able to hold the largest ratio.
  function automatic int unsigned jdiv_code_width(input int unsigned stages);
    return $clog2(2 * stages + 1);
  endfunction

endpackage

// File: rtl/jdiv_ratio_decode.sv
module jdiv_ratio_decode #(
  parameter int unsigned STAGES = 5,
  parameter int unsigned RW     = 4,
  parameter int unsigned IW     = 3
) (
  input  logic [RW-1:0]     ratio_code,
  output logic [RW-1:0]     eff_ratio,
  output logic [STAGES-1:0] win_mask,
  output logic              odd_mode,
  output logic [IW-1:0]     tap_hi
);

  localparam logic [RW-1:0] MAXR = RW'(2 * STAGES);
  localparam logic [RW-1:0] MINR = RW'(2);

  logic [RW-1:0] win_len;

  // Codes outside the usable range fold onto the longest division.
  function automatic logic [RW-1:0] fold_code(input logic [RW-1:0] c);
    if (c < MINR || c > MAXR) return MAXR;
    return c;
  endfunction

  // Number of stages taking part in the ring for a given ratio.
  function automatic logic [RW-1:0] active_len(input logic [RW-1:0] r);
    logic [RW:0] wide;
    wide = ({1'b0, r} + (RW+1)'(1)) >> 1;
    return wide[RW-1:0];
  endfunction

  always_comb begin
    eff_ratio = fold_code(ratio_code);
    win_len   = active_len(eff_ratio);
    odd_mode  = eff_ratio[0];
    tap_hi    = IW'(win_len - RW'(1));
  end

  for (genvar i = 0; i < STAGES; i++) begin : g_mask
    assign win_mask[i] = (RW'(i) < win_len);
  end

endmodule

// File: rtl/jdiv_feedback.sv
module jdiv_feedback #(
  parameter int unsigned STAGES = 5,
  parameter int unsigned IW     = 3
) (
  input  logic [STAGES-1:0] state,
  input  logic [STAGES-1:0] win_mask,
  input  logic              odd_mode,
  input  logic [IW-1:0]     tap_hi,
  output logic              fb_bit,
  output logic              step_legal
);

  logic          hi_bit;
  logic          lo_bit;
  logic [IW-1:0] tap_lo;
  int unsigned   edge_cnt;
  logic          window_zero;

  // Positions inside the window where neighbouring stages disagree.
  function automatic int unsigned count_edges(input logic [STAGES-1:0] v,
                                              input logic [STAGES-1:0] m);
    int unsigned n;
    n = 0;
    for (int i = 1; i < STAGES; i++) begin
      if (m[i] && (v[i] != v[i-1])) n++;
    end
    return n;
  endfunction

  always_comb begin
    tap_lo      = (tap_hi == '0) ? '0 : tap_hi - IW'(1);
    hi_bit      = state[tap_hi];
    lo_bit      = (tap_hi == '0) ? 1'b1 : state[tap_lo];
    fb_bit      = odd_mode ? ~(hi_bit & lo_bit) : ~hi_bit;
    edge_cnt    = count_edges(state, win_mask);
    window_zero = ((state & win_mask) == '0);
    step_legal  = (edge_cnt <= 1) && !(odd_mode && window_zero);
  end

endmodule

// File: rtl/jdiv_stage_ring.sv
module jdiv_stage_ring #(
  parameter int unsigned STAGES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              preset_en,
  input  logic [STAGES-1:0] jam,
  input  logic              fb_bit,
  input  logic              step_legal,
  output logic [STAGES-1:0] state
);

  always_ff @(posedge clk or posedge rst or posedge preset_en) begin
    if (rst)
      state <= '1;
    else if (preset_en)
      state <= ~jam;
    else if (!step_legal)
      state <= '1;
    else
      state <= {state[STAGES-2:0], fb_bit};
  end

  // R1: reset wins over everything.
  assert_reset_ones_R1: assert property (@(posedge clk)
    rst |-> (state == '1));

  // R2: preset holds the inverted jam word.
  assert_preset_load_R2: assert property (@(posedge clk) disable iff (rst)
    preset_en |-> (state == ~jam));

  // R3: the shift path moves every stage one place on.
  assert_shift_chain_R3: assert property (@(posedge clk) disable iff (rst || preset_en)
    ($past(!rst && !preset_en) && $past(step_legal))
      |-> (state[STAGES-1:1] == $past(state[STAGES-2:0])));

  // R7: a stray pattern goes back to all ones on the next edge.
  assert_antilock_R7: assert property (@(posedge clk) disable iff (rst || preset_en)
    !step_legal |=> (state == '1));

endmodule

// File: rtl/johnson_divider.sv
module johnson_divider #(
  parameter  int unsigned STAGES = jdiv_pkg::JDIV_STAGES_DEFAULT,
  localparam int unsigned RW     = jdiv_pkg::jdiv_code_width(STAGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              preset_en,
  input  logic [STAGES-1:0] jam,
  input  logic [RW-1:0]     ratio,
  output logic [STAGES-1:0] stage_q,
  output logic              div_out
);

  localparam int unsigned IW = (STAGES > 1) ? $clog2(STAGES) : 1;

  logic [RW-1:0]     eff_ratio;
  logic [STAGES-1:0] win_mask;
  logic              odd_mode;
  logic [IW-1:0]     tap_hi;
  logic              fb_bit;
  logic              step_legal;
  logic [STAGES-1:0] ring_state;

  jdiv_ratio_decode #(.STAGES(STAGES), .RW(RW), .IW(IW)) u_decode (
    .ratio_code (ratio),
    .eff_ratio  (eff_ratio),
    .win_mask   (win_mask),
    .odd_mode   (odd_mode),
    .tap_hi     (tap_hi)
  );

  jdiv_feedback #(.STAGES(STAGES), .IW(IW)) u_feedback (
    .state      (ring_state),
    .win_mask   (win_mask),
    .odd_mode   (odd_mode),
    .tap_hi     (tap_hi),
    .fb_bit     (fb_bit),
    .step_legal (step_legal)
  );

  jdiv_stage_ring #(.STAGES(STAGES)) u_ring (
    .clk        (clk),
    .rst        (rst),
    .preset_en  (preset_en),
    .jam        (jam),
    .fb_bit     (fb_bit),
    .step_legal (step_legal),
    .state      (ring_state)
  );

  assign stage_q = ring_state;
  assign div_out = ring_state[0];

  // R4: even division inverts the top tap into stage 0.
  assert_even_feedback_R4: assert property (@(posedge clk) disable iff (rst || preset_en)
    (step_legal && !odd_mode)
      |=> (stage_q[0] == ~$past(stage_q[tap_hi])));

  // R5: odd division feeds stage 0 from a NAND of two taps.
  assert_odd_feedback_R5: assert property (@(posedge clk) disable iff (rst || preset_en)
    (step_legal && odd_mode)
      |=> (stage_q[0] == ~($past(stage_q[tap_hi]) & $past(stage_q[tap_hi - IW'(1)]))));

  // R7: with a steady ratio a legal state stays legal.
  assert_legal_closed_R7: assert property (@(posedge clk) disable iff (rst || preset_en)
    step_legal |=> (step_legal || (ratio != $past(ratio))));

  // R6: folded codes select the longest even division.
  assert_fold_code_R6: assert property (@(posedge clk) disable iff (rst)
    ((ratio < RW'(2)) || (ratio > RW'(2 * STAGES)))
      |-> (!odd_mode && (win_mask == '1)));

endmodule

// File: tb/tb_johnson_divider.sv
`timescale 1ns/100ps
module tb_johnson_divider;

  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic       pre = 1'b0;
  logic [4:0] jam = 5'b0;
  logic [3:0] ratio = 4'd10;
  logic [4:0] stage_q;
  logic       div_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [4:0] mdl = 5'h1f;

  always #2 clk = ~clk;

  johnson_divider dut (
    .clk(clk), .rst(rst), .preset_en(pre), .jam(jam),
    .ratio(ratio), .stage_q(stage_q), .div_out(div_out)
  );

  function automatic int eff_of(input logic [3:0] code);
    if (code < 2 || code > 10) return 10;
    return int'(code);
  endfunction

  function automatic logic [4:0] model_step(input logic [4:0] st, input int r);
    int m;
    bit f;
    m = (r + 1) / 2;
    if (r % 2 == 0) f = !st[m-1];
    else            f = !(st[m-1] && st[m-2]);
    return {st[3:0], f};
  endfunction

  // Legal = the window is met when walking the cycle from all ones.
  function automatic bit model_legal(input logic [4:0] st, input int r);
    int m;
    logic [4:0] mask;
    logic [4:0] w;
    m = (r + 1) / 2;
    mask = 5'((1 << m) - 1);
    w = 5'h1f;
    for (int k = 0; k < r; k++) begin
      if ((w & mask) == (st & mask)) return 1;
      w = model_step(w, r);
    end
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model advances on each edge.
  always @(posedge clk) begin
    if (rst)                                 mdl <= 5'h1f;
    else if (pre)                            mdl <= ~jam;
    else if (!model_legal(mdl, eff_of(ratio))) mdl <= 5'h1f;
    else                                     mdl <= model_step(mdl, eff_of(ratio));
  end

  // Cycle-by-cycle comparison, in the middle of the high phase.
  always @(posedge clk) begin
    #1;
    if (!rst && !pre && !done) begin
      if (ratio < 2 || ratio > 10)
        check(stage_q == mdl, "R6", stage_q, mdl);
      else if (ratio[0])
        check(stage_q == mdl, "R5/R3", stage_q, mdl);
      else
        check(stage_q == mdl, "R4/R3", stage_q, mdl);
      check(div_out == stage_q[0], "R8", div_out, stage_q[0]);
    end
  end

  task automatic do_reset(input logic [3:0] code);
    @(negedge clk);
    rst = 1'b1;
    ratio = code;
    #0.5;
    check(stage_q == 5'h1f, "R1", stage_q, 5'h1f);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_preset(input logic [4:0] j);
    @(negedge clk);
    #1;
    jam = j;
    pre = 1'b1;
    #0.5;
    check(stage_q == ~j, "R2", stage_q, ~j);
    @(negedge clk);
    pre = 1'b0;
  endtask

  // Run and measure the spacing of div_out rises.
  task automatic run_period(input logic [3:0] code, input int cycles);
    int last;
    logic prev;
    int r;
    r = eff_of(code);
    last = -1;
    prev = div_out;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (!prev && div_out) begin
        if (last >= 0) check((k - last) == r, "R8", k - last, r);
        last = k;
      end
      prev = div_out;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: asynchronous reset, which beats preset.
    #1;
    rst = 1'b1;
    #0.5;
    check(stage_q == 5'h1f, "R1", stage_q, 5'h1f);
    pre = 1'b1;
    jam = 5'h1f;
    #0.5;
    check(stage_q == 5'h1f, "R1", stage_q, 5'h1f);
    @(negedge clk);
    pre = 1'b0;
    @(negedge clk);
    rst = 1'b0;

    // R4, R5, R8: every valid code; R6: invalid codes fold to 10.
    for (int c = 2; c <= 10; c++) begin
      do_reset(4'(c));
      run_period(4'(c), 5 * c + 4);
    end
    do_reset(4'd0);  run_period(4'd0, 44);
    do_reset(4'd1);  run_period(4'd1, 44);
    do_reset(4'd13); run_period(4'd13, 44);
    do_reset(4'd15); run_period(4'd15, 44);

    // R2: legal preset, counting resumes from it.
    do_reset(4'd10);
    do_preset(5'b11000);
    run_period(4'd10, 30);

    // R7: stray even-mode pattern returns to all ones.
    do_preset(5'b10101);
    @(negedge clk);
    check(stage_q == 5'h1f, "R7", stage_q, 5'h1f);

    // R7: all-zero window in odd mode is treated as stray.
    do_reset(4'd7);
    do_preset(5'b11111);
    @(negedge clk);
    check(stage_q == 5'h1f, "R7", stage_q, 5'h1f);

    // R7: all-zero in even mode is legal and keeps counting.
    do_reset(4'd8);
    do_preset(5'b11111);
    @(negedge clk);
    check(stage_q == 5'b00001, "R7", stage_q, 5'b00001);
    run_period(4'd8, 30);

    // R5: stray pattern under ratio 5 recovers and then divides by 5.
    do_reset(4'd5);
    do_preset(5'b11010);
    run_period(4'd5, 30);

    done = 1;
    #1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule